// File: doc/BRIEF.md
# Configuration Security Policy Gate

This block sits in front of a device's configuration engine and decides whether each full-load or partial-reload request is allowed to take effect. Every request carries the bitstream's encrypted flag and the selected key store (battery-held RAM or fuses). It also carries the verdicts of the key comparison and the authentication digest, which are computed elsewhere, along with the port it arrived on, the master/slave role and the data bus width. The block combines these with the fuse-held policy bits and the readback security level.

The block registers its verdict and announces it with a one-cycle strobe. It tracks whether the fabric is empty or configured, and drives the DONE level, an error pulse on the active-low INIT line, a readback permission flag, and a select that runs the configuration clock at half rate. It also drives a status word. A reload event (power-on, program pulse or internal reprogram command) returns the device to the empty state. This is the only way to permit another full load.

Top module: `cfg_sec_gate`

## Requirements
- R1: After reset or a `reload_req` cycle the outputs read done=0, readback_en=0, cclk_half=0, init_b=1 and status=0. A full load (req_partial=0) is only eligible while the device is empty, that is, after reset or reload and before any accepted full load.
- R2: A request sampled with req_valid=1 and reload_req=0 yields dec_valid=1 in the following cycle, with dec_accept giving the verdict. A request that coincides with reload_req produces no verdict.
- R3: With fuse_aes_only=1, a request on the external port (req_port_int=0) is accepted only if it is encrypted (req_encrypted=1) and uses the fuse key (req_key_fuse=1).
- R4: With fuse_aes_only=0, an unencrypted full load into an empty device is accepted whatever key source, key match and digest inputs say.
- R5: An accepted encrypted full or partial load drives readback_en to 0. An accepted unencrypted full load drives it to 1.
- R6: An external partial load is rejected when it is unencrypted, or when fuse_aes_excl=1 or sec_level2=1. Partial loads require a configured device.
- R7: A partial load on the internal port may be unencrypted and is then accepted without regard to the exclusive-lock bits.
- R8: A request that passes policy but is encrypted with key_match=0 or hmac_ok=0 is rejected, and sets status bit 8 until the next reload. It drives init_b low for INIT_PULSE_CYCLES cycles starting the cycle after the request when fallback_en=1, and leaves init_b high otherwise.
- R9: Status bit 1 is the decryptor-in-use flag of the last accepted full load. Bits 4 (end of startup) and 14 (DONE pin) follow done. All other status bits read 0.
- R10: Encrypted loads in slave mode (req_master=0) require req_width=2'b00 (x8). Encrypted master loads accept 2'b00 or 2'b01 (x16). Width 2'b10 (x32) and 2'b11 are refused for encrypted data. An accepted encrypted master x16 full load sets cclk_half until reload.
- R11: A rejected request leaves done, readback_en and cclk_half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reload_req | input | 1 | Power-on, program pulse or internal reprogram: empties the device |
| req_valid | input | 1 | Request present this cycle |
| req_partial | input | 1 | 1 = partial reload, 0 = full load |
| req_encrypted | input | 1 | Bitstream is encrypted |
| req_key_fuse | input | 1 | 1 = fuse key selected, 0 = battery-RAM key |
| key_match | input | 1 | Key check verdict from the decryptor |
| hmac_ok | input | 1 | Authentication digest verdict |
| req_port_int | input | 1 | 1 = internal configuration port, 0 = external |
| req_master | input | 1 | 1 = master mode, 0 = slave mode |
| req_width | input | 2 | Bus width: 00 x8, 01 x16, 10 x32, 11 reserved |
| fuse_aes_only | input | 1 | Fuse policy: external loads must use the fuse key |
| fuse_aes_excl | input | 1 | Fuse policy: external partial loads blocked |
| sec_level2 | input | 1 | Readback security level 2 selected |
| fallback_en | input | 1 | Fallback enabled: emit INIT error pulse |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Verdict: 1 accepted |
| done | output | 1 | DONE pin level |
| init_b | output | 1 | Active-low INIT line, error pulse |
| readback_en | output | 1 | External readback allowed |
| cclk_half | output | 1 | Configuration clock at half rate |
| status | output | STATUS_W | Configuration status word |

## Verification
The hardest situation to reach is an authentication failure on a partial load into a device that is already configured with an encrypted image and fallback enabled. Here the INIT pulse must run for its full length, the error bit must latch, and DONE, readback and clock select must all hold. The stimulus reaches it with a reload, then an encrypted master x16 full load, then exclusive-lock rejections, then an accepted encrypted external partial load, and finally the same partial load with a failing digest. A long random phase follows. It applies occasional reloads and random policy bits, and a behavioural model checks every output on every cycle.

// File: rtl/cfg_gate_pkg.sv
// Package: shared types and status bit positions for the configuration policy gate.
// Assumes: status word at least 15 bits wide.
package cfg_gate_pkg;

    typedef enum logic [1:0] {
        BW_X8   = 2'b00,
        BW_X16  = 2'b01,
        BW_X32  = 2'b10,
        BW_RSVD = 2'b11
    } bus_width_e;

    typedef struct packed {
        logic       partial;
        logic       encrypted;
        logic       key_fuse;
        logic       key_match;
        logic       hmac_ok;
        logic       port_int;
        logic       master;
        bus_width_e width;
    } cfg_req_t;

    typedef struct packed {
        logic aes_only;
        logic aes_excl;
        logic sec_lvl2;
    } fuse_pol_t;

    typedef struct packed {
        logic accept;
        logic auth_fail;
        logic half_clk;
    } cfg_verdict_t;

    localparam int STAT_DEC_BIT  = 1;
    localparam int STAT_EOS_BIT  = 4;
    localparam int STAT_AUTH_BIT = 8;
    localparam int STAT_DONE_BIT = 14;

endpackage

// File: rtl/cfg_gate_rules.sv
// Module: combinational policy evaluation of one request.
// Assumes: the key and digest verdicts are valid in the same cycle as the request.
module cfg_gate_rules
    import cfg_gate_pkg::*;
(
    input  cfg_req_t     req,
    input  fuse_pol_t    pol,
    input  logic         dev_empty,
    output cfg_verdict_t verdict
);

    logic width_ok;
    logic key_src_ok;
    logic stage_ok;
    logic path_ok;
    logic policy_ok;

    // Bus width legality for encrypted data.
    always_comb begin
        if (!req.encrypted)
            width_ok = 1'b1;
        else if (req.master)
            width_ok = (req.width == BW_X8) || (req.width == BW_X16);
        else
            width_ok = (req.width == BW_X8);
    end

    // Fuse-key-only rule on external ports.
    always_comb begin
        key_src_ok = 1'b1;
        if (pol.aes_only && !req.port_int)
            key_src_ok = req.encrypted && req.key_fuse;
    end

    // Load-stage and port path legality.
    always_comb begin
        if (req.partial) begin
            stage_ok = !dev_empty;
            path_ok  = req.port_int ||
                       (req.encrypted && !pol.aes_excl && !pol.sec_lvl2);
        end else begin
            stage_ok = dev_empty;
            path_ok  = 1'b1;
        end
    end

    // Final verdict: policy first, then authentication.
    always_comb begin
        policy_ok         = width_ok && key_src_ok && stage_ok && path_ok;
        verdict.auth_fail = policy_ok && req.encrypted &&
                            !(req.key_match && req.hmac_ok);
        verdict.accept    = policy_ok && !verdict.auth_fail;
        verdict.half_clk  = req.encrypted && req.master && (req.width == BW_X16);
    end

endmodule

// File: rtl/cfg_gate_pulse.sv
// Module: stretches a one-cycle error event into an active-low pulse of CYC cycles.
// Assumes: clr has priority over fire; a new fire restarts the pulse.
module cfg_gate_pulse #(
    parameter int CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fire,
    output logic low_n
);

    generate
        if (CYC <= 1) begin : g_single
            logic q;
            // One-cycle pulse register.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) q <= 1'b1;
                else               q <= !fire;
            end
            assign low_n = q;
        end else begin : g_count
            localparam int CW = $clog2(CYC + 1);
            logic [CW-1:0] cnt;
            // Down-counter that holds the line low while nonzero.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)   cnt <= '0;
                else if (fire)       cnt <= CW'(CYC);
                else if (cnt != '0)  cnt <= cnt - 1'b1;
            end
            assign low_n = (cnt == '0);
        end
    endgenerate

endmodule

// File: rtl/cfg_gate_state.sv
// Module: registered configuration state and verdict strobe.
// Assumes: reload has priority over any request in the same cycle.
module cfg_gate_state
    import cfg_gate_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload,
    input  logic         req_valid,
    input  logic         req_partial,
    input  logic         req_enc,
    input  cfg_verdict_t verdict,
    output logic         dev_empty,
    output logic         dec_valid,
    output logic         dec_accept,
    output logic         done_q,
    output logic         rb_q,
    output logic         dec_en_q,
    output logic         half_q,
    output logic         auth_err_q
);

    logic take;
    assign take = req_valid && verdict.accept;

    // State update on reset, reload or an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            dev_empty  <= 1'b1;
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            done_q     <= 1'b0;
            rb_q       <= 1'b0;
            dec_en_q   <= 1'b0;
            half_q     <= 1'b0;
            auth_err_q <= 1'b0;
        end else begin
            dec_valid  <= req_valid;
            dec_accept <= take;
            if (take && !req_partial) begin
                dev_empty <= 1'b0;
                done_q    <= 1'b1;
                rb_q      <= !req_enc;
                dec_en_q  <= req_enc;
                half_q    <= verdict.half_clk;
            end else if (take && req_enc) begin
                rb_q <= 1'b0;
            end
            if (req_valid && verdict.auth_fail)
                auth_err_q <= 1'b1;
        end
    end

    AST_ACCEPT_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid); // R2

    AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> ($stable(done_q) && $stable(rb_q) && $stable(half_q))); // R11

endmodule

// File: rtl/cfg_sec_gate.sv
// Module: top of the configuration security policy gate.
// Assumes: decryption and digest verdicts arrive with the request; STATUS_W >= 15.
module cfg_sec_gate
    import cfg_gate_pkg::*;
#(
    parameter int INIT_PULSE_CYCLES = 2,
    parameter int STATUS_W          = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reload_req,
    input  logic                req_valid,
    input  logic                req_partial,
    input  logic                req_encrypted,
    input  logic                req_key_fuse,
    input  logic                key_match,
    input  logic                hmac_ok,
    input  logic                req_port_int,
    input  logic                req_master,
    input  logic [1:0]          req_width,
    input  logic                fuse_aes_only,
    input  logic                fuse_aes_excl,
    input  logic                sec_level2,
    input  logic                fallback_en,
    output logic                dec_valid,
    output logic                dec_accept,
    output logic                done,
    output logic                init_b,
    output logic                readback_en,
    output logic                cclk_half,
    output logic [STATUS_W-1:0] status
);

    cfg_req_t     req;
    fuse_pol_t    pol;
    cfg_verdict_t verdict;
    logic         dev_empty;
    logic         dec_en_q;
    logic         auth_err_q;
    logic         err_fire;

    // Pack the request and policy fields.
    always_comb begin
        req.partial   = req_partial;
        req.encrypted = req_encrypted;
        req.key_fuse  = req_key_fuse;
        req.key_match = key_match;
        req.hmac_ok   = hmac_ok;
        req.port_int  = req_port_int;
        req.master    = req_master;
        req.width     = bus_width_e'(req_width);
        pol.aes_only  = fuse_aes_only;
        pol.aes_excl  = fuse_aes_excl;
        pol.sec_lvl2  = sec_level2;
    end

    cfg_gate_rules u_rules (
        .req       (req),
        .pol       (pol),
        .dev_empty (dev_empty),
        .verdict   (verdict)
    );

    cfg_gate_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (reload_req),
        .req_valid  (req_valid),
        .req_partial(req_partial),
        .req_enc    (req_encrypted),
        .verdict    (verdict),
        .dev_empty  (dev_empty),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .done_q     (done),
        .rb_q       (readback_en),
        .dec_en_q   (dec_en_q),
        .half_q     (cclk_half),
        .auth_err_q (auth_err_q)
    );

    assign err_fire = req_valid && !reload_req && verdict.auth_fail && fallback_en;

    cfg_gate_pulse #(.CYC(INIT_PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reload_req),
        .fire  (err_fire),
        .low_n (init_b)
    );

    // Assemble the status word.
    always_comb begin
        status                = '0;
        status[STAT_DEC_BIT]  = dec_en_q;
        status[STAT_EOS_BIT]  = done;
        status[STAT_AUTH_BIT] = auth_err_q;
        status[STAT_DONE_BIT] = done;
    end

    AST_AES_ONLY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_accept && $past(fuse_aes_only && !req_port_int)) |-> $past(req_encrypted && req_key_fuse)); // R3

    AST_ENC_BLOCKS_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_accept && $past(req_encrypted)) |-> !readback_en); // R5

    AST_INIT_NEEDS_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_b) |-> $past(fallback_en)); // R8

    AST_HALF_NO_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_half |-> !readback_en); // R10

endmodule

// File: tb/cfg_sec_gate_tb_top.sv
module cfg_sec_gate_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int INIT_CYC   = 2;
    localparam int ACC = 0, REJ = 1, AFAIL = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reload_req = 0, req_valid = 0, req_partial = 0, req_encrypted = 0;
    logic req_key_fuse = 0, key_match = 0, hmac_ok = 0, req_port_int = 0, req_master = 0;
    logic [1:0] req_width = 2'b00;
    logic fuse_aes_only = 0, fuse_aes_excl = 0, sec_level2 = 0, fallback_en = 0;
    logic dec_valid, dec_accept, done, init_b, readback_en, cclk_half;
    logic [15:0] status;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_sec_gate #(.INIT_PULSE_CYCLES(INIT_CYC), .STATUS_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .reload_req(reload_req), .req_valid(req_valid),
        .req_partial(req_partial), .req_encrypted(req_encrypted), .req_key_fuse(req_key_fuse),
        .key_match(key_match), .hmac_ok(hmac_ok), .req_port_int(req_port_int),
        .req_master(req_master), .req_width(req_width), .fuse_aes_only(fuse_aes_only),
        .fuse_aes_excl(fuse_aes_excl), .sec_level2(sec_level2), .fallback_en(fallback_en),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .done(done), .init_b(init_b),
        .readback_en(readback_en), .cclk_half(cclk_half), .status(status)
    );

    // Behavioural reference model state
    bit m_live = 0;
    bit m_empty = 1, m_done = 0, m_rb = 0, m_dec = 0, m_half = 0, m_err = 0;
    bit m_valid = 0, m_acc = 0;
    int m_init = 0;

    function automatic int judge();
        if (req_partial) begin
            if (m_empty) return REJ;
            if (!req_port_int) begin
                if (!req_encrypted) return REJ;
                if (fuse_aes_excl || sec_level2) return REJ;
            end
        end else if (!m_empty) return REJ;
        if (fuse_aes_only && !req_port_int && !(req_encrypted && req_key_fuse)) return REJ;
        if (req_encrypted) begin
            if (req_master) begin
                if (req_width > 2'd1) return REJ;
            end else if (req_width != 2'd0) return REJ;
            if (!(key_match && hmac_ok)) return AFAIL;
        end
        return ACC;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || reload_req) begin
            if (!rst_n) m_live = 1;
            m_empty = 1; m_done = 0; m_rb = 0; m_dec = 0; m_half = 0; m_err = 0;
            m_valid = 0; m_acc = 0; m_init = 0;
        end else begin
            int v;
            v = judge();
            m_valid = req_valid;
            m_acc = req_valid && (v == ACC);
            if (m_init > 0) m_init = m_init - 1;
            if (m_acc) begin
                if (!req_partial) begin
                    m_empty = 0; m_done = 1; m_rb = !req_encrypted; m_dec = req_encrypted;
                    m_half = req_encrypted && req_master && (req_width == 2'd1);
                end else if (req_encrypted) m_rb = 0;
            end
            if (req_valid && v == AFAIL) begin
                m_err = 1;
                if (fallback_en) m_init = INIT_CYC;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (m_live && !finished) begin
            logic [15:0] ms;
            ms = '0;
            ms[1] = m_dec; ms[4] = m_done; ms[8] = m_err; ms[14] = m_done;
            chk("R2 model dec_valid", {31'd0, dec_valid}, {31'd0, m_valid});
            chk("R2 model dec_accept", {31'd0, dec_accept}, {31'd0, m_acc});
            chk("R9 model done", {31'd0, done}, {31'd0, m_done});
            chk("R5 model readback_en", {31'd0, readback_en}, {31'd0, m_rb});
            chk("R8 model init_b", {31'd0, init_b}, {31'd0, (m_init == 0)});
            chk("R10 model cclk_half", {31'd0, cclk_half}, {31'd0, m_half});
            chk("R9 model status", {16'd0, status}, {16'd0, ms});
        end
    end

    task automatic send(input bit pa, input bit en, input bit kf, input bit km, input bit ho,
                        input bit pi, input bit ms, input logic [1:0] w);
        @(negedge clk);
        req_partial = pa; req_encrypted = en; req_key_fuse = kf; key_match = km;
        hmac_ok = ho; req_port_int = pi; req_master = ms; req_width = w; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_reload();
        @(negedge clk); reload_req = 1;
        @(negedge clk); reload_req = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset done", {31'd0, done}, 0);
        chk("R1 reset readback", {31'd0, readback_en}, 0);
        chk("R1 reset status", {16'd0, status}, 0);
        chk("R1 reset init_b", {31'd0, init_b}, 1);
        chk("R1 reset cclk_half", {31'd0, cclk_half}, 0);

        // R4 unencrypted full load, key inputs irrelevant, x32 slave
        send(0, 0, 1, 0, 0, 0, 0, 2'b10);
        chk("R4 plain full accepted", {30'd0, dec_valid, dec_accept}, 3);
        chk("R5 plain load readback on", {31'd0, readback_en}, 1);
        chk("R9 status after plain", {16'd0, status}, 32'h4010);

        // R1 second full load refused while configured; R11 state kept
        send(0, 0, 0, 0, 0, 0, 0, 2'b00);
        chk("R1 full load when configured", {30'd0, dec_valid, dec_accept}, 2);
        chk("R11 done kept", {31'd0, done}, 1);
        chk("R11 readback kept", {31'd0, readback_en}, 1);

        // R7 internal unencrypted partial
        send(1, 0, 0, 0, 0, 1, 0, 2'b10);
        chk("R7 internal plain partial", {31'd0, dec_accept}, 1);
        chk("R7 readback unchanged", {31'd0, readback_en}, 1);

        // R6 external unencrypted partial refused
        send(1, 0, 0, 1, 1, 0, 0, 2'b00);
        chk("R6 external plain partial", {31'd0, dec_accept}, 0);

        // R10 encrypted slave x16 refused, encrypted master x16 accepted
        do_reload();
        chk("R1 reload clears done", {31'd0, done}, 0);
        send(0, 1, 0, 1, 1, 0, 0, 2'b01);
        chk("R10 slave x16 encrypted", {31'd0, dec_accept}, 0);
        send(0, 1, 0, 1, 1, 0, 1, 2'b10);
        chk("R10 master x32 encrypted", {31'd0, dec_accept}, 0);
        send(0, 1, 0, 1, 1, 0, 1, 2'b01);
        chk("R10 master x16 encrypted", {31'd0, dec_accept}, 1);
        chk("R10 half clock", {31'd0, cclk_half}, 1);
        chk("R5 encrypted load readback off", {31'd0, readback_en}, 0);
        chk("R9 status after encrypted", {16'd0, status}, 32'h4012);

        // R6 exclusive lock and level 2
        fuse_aes_excl = 1;
        send(1, 1, 0, 1, 1, 0, 0, 2'b00);
        chk("R6 partial with exclusive fuse", {31'd0, dec_accept}, 0);
        fuse_aes_excl = 0; sec_level2 = 1;
        send(1, 1, 0, 1, 1, 0, 0, 2'b00);
        chk("R6 partial with level2", {31'd0, dec_accept}, 0);
        sec_level2 = 0;
        send(1, 1, 0, 1, 1, 0, 0, 2'b00);
        chk("R6 encrypted external partial", {31'd0, dec_accept}, 1);

        // R8 digest failure with fallback
        fallback_en = 1;
        send(1, 1, 0, 1, 0, 0, 0, 2'b00);
        chk("R8 failed digest rejected", {30'd0, dec_valid, dec_accept}, 2);
        chk("R8 init low first", {31'd0, init_b}, 0);
        chk("R8 error bit", {31'd0, status[8]}, 1);
        chk("R11 done kept on auth fail", {31'd0, done}, 1);
        @(negedge clk);
        chk("R8 init low second", {31'd0, init_b}, 0);
        @(negedge clk);
        chk("R8 init released", {31'd0, init_b}, 1);
        fallback_en = 0;

        // R3 fuse key only
        do_reload();
        fuse_aes_only = 1;
        send(0, 0, 0, 1, 1, 0, 0, 2'b00);
        chk("R3 plain refused", {31'd0, dec_accept}, 0);
        send(0, 1, 0, 1, 1, 0, 0, 2'b00);
        chk("R3 battery key refused", {31'd0, dec_accept}, 0);
        send(0, 1, 1, 1, 1, 0, 0, 2'b00);
        chk("R3 fuse key accepted", {31'd0, dec_accept}, 1);
        chk("R10 x8 no half clock", {31'd0, cclk_half}, 0);
        fuse_aes_only = 0;

        // R8 key mismatch without fallback
        do_reload();
        send(0, 1, 0, 0, 1, 0, 0, 2'b00);
        chk("R8 mismatch rejected", {31'd0, dec_accept}, 0);
        chk("R8 no pulse without fallback", {31'd0, init_b}, 1);
        chk("R8 error flagged", {31'd0, status[8]}, 1);
        chk("R8 done stays low", {31'd0, done}, 0);

        // R2 request coinciding with reload yields no verdict
        @(negedge clk);
        req_partial = 0; req_encrypted = 0; req_port_int = 0; req_valid = 1; reload_req = 1;
        @(negedge clk);
        req_valid = 0; reload_req = 0;
        chk("R2 no verdict under reload", {31'd0, dec_valid}, 0);
        chk("R1 empty after reload", {31'd0, done}, 0);

        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reload_req    = ($urandom_range(0, 15) == 0);
            req_valid     = $urandom_range(0, 1);
            req_partial   = $urandom_range(0, 1);
            req_encrypted = $urandom_range(0, 1);
            req_key_fuse  = $urandom_range(0, 1);
            key_match     = ($urandom_range(0, 3) != 0);
            hmac_ok       = ($urandom_range(0, 3) != 0);
            req_port_int  = $urandom_range(0, 1);
            req_master    = $urandom_range(0, 1);
            req_width     = 2'($urandom_range(0, 3));
            fallback_en   = $urandom_range(0, 1);
            if ($urandom_range(0, 31) == 0) begin
                fuse_aes_only = $urandom_range(0, 1);
                fuse_aes_excl = $urandom_range(0, 1);
                sec_level2    = $urandom_range(0, 1);
            end
        end
        @(negedge clk);
        req_valid = 0; reload_req = 0;
        repeat (4) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule